// File: doc/BRIEF.md
# Microcoded Multiply-Decrement Sequencer

This block is a tiny arithmetic engine made of two 16-bit working registers: a count register `N` and an accumulator `ACC`. It also has a decrementer, a truncating multiplier and a test for "N is zero". No fixed state machine steers it. A sequencer steps through a writable table of sixteen control words instead. Each word states which registers load in that step and where each register takes its value from. It also states whether the step ends the program and how the next step is chosen.

Software first fills the table through a simple write port and then pulses `start` with an operand on `n_in`. With one table the block returns N*(N-1). With another it loops on the zero test and returns N!. When the program reaches a step marked as final, the block holds `done` high and `result` steady until the next start.

Top module: `ucode_dp_ctrl`

## Requirements
- R1: A register changes only on a clock edge of an executed step whose control word sets that register's load bit. Bit 0 of the word is the load bit for N and bit 1 is the load bit for ACC. In every other cycle both registers hold their values.
- R2: Control word layout: bits [3:2] select the source for N and bits [5:4] select the source for ACC. The source codes are 0 = `n_in`, 1 = constant 1, 2 = N-1 (wrapping), 3 = N*ACC.
- R3: A cycle with `start` high puts the sequencer at step 0 and in the running state. Every following clock edge then executes one step.
- R4: Bits [8:7] choose the next step and bits [12:9] hold the target. The codes are 0 = step+1 (15 wraps to 0), 1 = target if N==0, 2 = target always, 3 = target if N!=0. The zero test uses N as it was before that step's own load.
- R5: A step with bit 6 set performs its loads and then stops the sequencer. `done` goes high after that edge and stays high, with `result` (ACC) unchanged, until the next `start`. `done` is low while a program runs.
- R6: When one step loads both registers, both sources use the register values from before that step. This lets the multiply and the decrement of the loop share a single step.
- R7: While a program is running, table writes are dropped. When the block is idle or done, `tbl_we` stores `tbl_word` at `tbl_addr`.
- R8: The product N*ACC is truncated to its low 16 bits.
- R9: After reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_word | input | 13 | Control word to store |
| start | input | 1 | Begin the program at step 0 |
| n_in | input | 16 | Operand for source code 0 |
| result | output | 16 | Accumulator contents |
| done | output | 1 | Program finished; result valid |

## Verification
The bench uses the default 16-bit data width and the 16-entry table. Small operands therefore run their loops within a few dozen steps. Operands of 9! and 300*299 overflow 16 bits, which brings the truncation of the product within reach. Three different programs run on the same hardware: a straight-line program, a loop that exits on zero, and a loop that repeats on nonzero. The bench checks the cycle counts from start to done for these programs, which pins down both branch codes and the one-step-per-cycle timing.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
    localparam int STEP_AW = 4;
    localparam int DEPTH   = 1 << STEP_AW;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_DEC  = 2'd2,
        SRC_PROD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        BR_SEQ     = 2'd0,
        BR_ZERO    = 2'd1,
        BR_ALWAYS  = 2'd2,
        BR_NONZERO = 2'd3
    } br_e;

    // packed MSB first: target, branch mode, halt, acc source, n source, load bits
    typedef struct packed {
        logic [STEP_AW-1:0] tgt;
        br_e                br;
        logic               halt;
        src_e               acc_sel;
        src_e               n_sel;
        logic               ld_acc;
        logic               ld_n;
    } cw_t;

    localparam int CW_W = $bits(cw_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;
endpackage

// File: rtl/ucode_store.sv
module ucode_store
    import ucode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [STEP_AW-1:0] wr_addr,
    input  logic [CW_W-1:0]    wr_word,
    input  logic               busy,
    input  logic [STEP_AW-1:0] rd_addr,
    output cw_t                rd_word
);
    logic [CW_W-1:0] mem_q [DEPTH];
    logic [CW_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en && !busy) mem_d[wr_addr] = wr_word;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = cw_t'(mem_q[rd_addr]);

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  cw_t                cw,
    input  logic               n_zero,
    output logic [STEP_AW-1:0] step,
    output logic               running,
    output logic               done
);
    typedef struct packed {
        seq_st_e            st;
        logic [STEP_AW-1:0] step;
    } seq_s;

    seq_s s_q, s_d;
    logic take;

    always_comb begin
        unique case (cw.br)
            BR_ZERO:    take = n_zero;
            BR_ALWAYS:  take = 1'b1;
            BR_NONZERO: take = !n_zero;
            default:    take = 1'b0;
        endcase
        s_d = s_q;
        if (start) begin
            s_d.st   = ST_RUN;
            s_d.step = '0;
        end else if (s_q.st == ST_RUN) begin
            if (cw.halt)   s_d.st   = ST_DONE;
            else if (take) s_d.step = cw.tgt;
            else           s_d.step = s_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.step <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step    = s_q.step;
    assign running = (s_q.st == ST_RUN);
    assign done    = (s_q.st == ST_DONE);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && step == '0));
    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R5
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({running, done}));
    // R4
    jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start && !cw.halt && cw.br == BR_ALWAYS) |=> (step == $past(cw.tgt)));
endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
    import ucode_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ld_acc,
    input  src_e              n_sel,
    input  src_e              acc_sel,
    input  logic [DATA_W-1:0] n_in,
    output logic              n_zero,
    output logic [DATA_W-1:0] acc
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] n;
        logic [DATA_W-1:0] acc;
    } dp_s;

    dp_s r_q, r_d;
    logic [DATA_W-1:0]   dec_v;
    logic [2*DATA_W-1:0] prod_full;
    logic [DATA_W-1:0]   prod_v;

    function automatic logic [DATA_W-1:0] pick(src_e sel, logic [DATA_W-1:0] ext,
                                               logic [DATA_W-1:0] dv, logic [DATA_W-1:0] pv);
        unique case (sel)
            SRC_EXT: return ext;
            SRC_ONE: return ONE;
            SRC_DEC: return dv;
            default: return pv;
        endcase
    endfunction

    always_comb begin
        dec_v     = r_q.n - ONE;
        prod_full = r_q.n * r_q.acc;
        prod_v    = prod_full[DATA_W-1:0];
        r_d       = r_q;
        if (ld_n)   r_d.n   = pick(n_sel,   n_in, dec_v, prod_v);
        if (ld_acc) r_d.acc = pick(acc_sel, n_in, dec_v, prod_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign n_zero = (r_q.n == '0);
    assign acc    = r_q.acc;

    // R1
    n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (r_q.n == $past(r_q.n)));
    // R1
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_acc |=> (r_q.acc == $past(r_q.acc)));
    // R6
    dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && ld_acc && n_sel == SRC_DEC && acc_sel == SRC_PROD)
        |=> (r_q.n + ONE == $past(r_q.n)));
endmodule

// File: rtl/ucode_dp_ctrl.sv
module ucode_dp_ctrl
    import ucode_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [STEP_AW-1:0] tbl_addr,
    input  logic [CW_W-1:0]    tbl_word,
    input  logic               start,
    input  logic [DATA_W-1:0]  n_in,
    output logic [DATA_W-1:0]  result,
    output logic               done
);
    cw_t                cw;
    logic [STEP_AW-1:0] step;
    logic               running;
    logic               n_zero;

    ucode_store u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_word(tbl_word),
        .busy(running), .rd_addr(step), .rd_word(cw)
    );

    ucode_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cw(cw),
        .n_zero(n_zero), .step(step), .running(running), .done(done)
    );

    ucode_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .ld_n(running && !start && cw.ld_n),
        .ld_acc(running && !start && cw.ld_acc),
        .n_sel(cw.n_sel), .acc_sel(cw.acc_sel),
        .n_in(n_in), .n_zero(n_zero), .acc(result)
    );

    // R9
    rst_chk: assert property (@(posedge clk) $past(!rst_n) |-> (!done && result == '0));
endmodule

// File: tb/sim_ucode_dp_ctrl.sv
module sim_ucode_dp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [12:0] tbl_word = '0;
    logic        start = 1'b0;
    logic [15:0] n_in = '0;
    logic [15:0] result;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int steps;

    ucode_dp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_word(tbl_word), .start(start), .n_in(n_in),
        .result(result), .done(done)
    );

    always #4 clk = ~clk;

    // word = {tgt[12:9], br[8:7], halt[6], acc_sel[5:4], n_sel[3:2], ld_acc[1], ld_n[0]}
    function automatic logic [12:0] w(bit ldn, bit ldacc, bit [1:0] nsel, bit [1:0] asel,
                                      bit halt, bit [1:0] br, bit [3:0] tgt);
        return {tgt, br, halt, asel, nsel, ldacc, ldn};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [12:0] word);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_word = word;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run(int n, bit poke);
        @(negedge clk);
        start = 1'b1; n_in = 16'(n);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R5 done low while running", done, 0);
        if (poke) begin
            tbl_we = 1'b1; tbl_addr = 4'd0; tbl_word = '0;
        end
        steps = 1;
        while (!done && steps < 500) begin
            @(negedge clk);
            tbl_we = 1'b0;
            steps++;
        end
        tbl_we = 1'b0;
        steps--;
    endtask

    task automatic load_mul;
        wr(0, w(1, 1, 0, 0, 0, 0, 0));
        wr(1, w(1, 0, 2, 0, 0, 0, 0));
        wr(2, w(0, 1, 0, 3, 1, 0, 0));
    endtask

    task automatic load_fact;
        wr(0, w(1, 1, 0, 1, 0, 0, 0));
        wr(1, w(0, 0, 0, 0, 0, 1, 3));
        wr(2, w(1, 1, 2, 3, 0, 2, 1));
        wr(3, w(0, 0, 0, 0, 1, 0, 0));
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R9 done after reset", done, 0);
        chk(result == 16'd0, "R9 result after reset", result, 0);
    endtask

    task automatic t_mul;
        load_mul();
        run(7, 0);
        chk(result == 16'd42, "R2 N*(N-1) N=7", result, 42);
        chk(steps == 3, "R3 straight-line step count", steps, 3);
        run(0, 0);
        chk(result == 16'd0, "R2 N*(N-1) N=0", result, 0);
        run(300, 0);
        chk(result == 16'd24164, "R8 truncated 300*299", result, 24164);
    endtask

    task automatic t_fact;
        load_fact();
        run(5, 0);
        chk(result == 16'd120, "R6 factorial 5", result, 120);
        chk(steps == 13, "R4 branch-on-zero loop steps N=5", steps, 13);
        run(0, 0);
        chk(result == 16'd1, "R4 factorial 0 exits at once", result, 1);
        chk(steps == 3, "R4 zero exit steps", steps, 3);
        run(9, 0);
        chk(result == 16'd35200, "R8 factorial 9 truncated", result, 35200);
    endtask

    task automatic t_hold;
        logic [15:0] keep;
        keep = result;
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R5 done held", done, 1);
        chk(result == keep, "R1 result held after halt", result, keep);
    endtask

    task automatic t_frozen;
        run(5, 1);
        chk(result == 16'd120, "R7 write during run dropped", result, 120);
        run(4, 0);
        chk(result == 16'd24, "R7 entry 0 intact", result, 24);
    endtask

    task automatic t_nonzero;
        wr(0, w(1, 0, 0, 0, 0, 0, 0));
        wr(1, w(1, 0, 2, 0, 0, 3, 1));
        wr(2, w(0, 1, 0, 2, 1, 0, 0));
        run(3, 0);
        chk(result == 16'd65534, "R4 nonzero loop result", result, 65534);
        chk(steps == 6, "R4 nonzero loop steps", steps, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul();
        t_hold();
        t_fact();
        t_frozen();
        t_nonzero();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule